// File: doc/BRIEF.md
# Nibble-Coded Fetch-Decode-Execute Processor

This block is a small multi-cycle processor. It runs fixed 16-bit instructions held in a 256-byte memory that it shares with its data. Each instruction word has four nibbles. The top nibble selects the operation. The others name registers or form an 8-bit address. The core holds sixteen 8-bit working registers, an 8-bit program counter and a 16-bit instruction register. It walks each instruction through fetch, decode and execute states.

The memory sits outside the core on a single synchronous port. An address is presented in one cycle and its byte comes back after the next clock edge. A write happens on the edge at which the write enable is high. One address is reserved for output. A store to that address updates memory as usual and also shows its byte on a dedicated output with a one-cycle valid strobe. The current PC and instruction register are brought out for debug, and a status output shows that the machine has stopped.

Top module: `nibble_cpu`

## Requirements
- R1: While reset is high and in the first cycle after it, the PC reads 0x00, the instruction register reads 0x0000, the stopped flag is low and no write is issued. All sixteen working registers read zero, so a store of any register before it is loaded writes 0x00.
- R2: An instruction is fetched as two bytes: the byte at PC goes to instruction bits 15:8 and the byte at PC+1 goes to bits 7:0. Three clock edges after fetch starts, the instruction register holds the word and the PC has advanced by two.
- R3: Opcode 0x1, encoded as 1 R A A, copies the memory byte at address AA into register R.
- R4: Opcode 0x3, encoded as 3 R A A, writes register R to address AA with a write enable that is high for exactly one cycle.
- R5: Opcode 0x5, encoded as 5 R S T, places S+T modulo 256 in register R. No flags are kept, and R may equal S or T.
- R6: Opcode 0xB, encoded as B R A A, loads AA into the PC when register R equals register 0.
- R7: When the registers in an 0xB instruction differ, execution continues with the next sequential instruction.
- R8: Opcode 0xC stops the machine. The stopped flag stays high, the PC stays fixed, and no further fetch or write occurs until reset.
- R9: A store to the reserved output address (default 0xFF) writes memory and also pulses the output-valid signal for one cycle with the stored byte. Stores to other addresses never pulse it.
- R10: Opcodes 0x0, 0x2, 0x4, 0x6-0xA and 0xD-0xF change no register and issue no write. Execution then moves on to the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 8 | Memory byte address (registered) |
| mem_we | output | 1 | Memory write enable (registered) |
| mem_wdata | output | 8 | Memory write byte (registered) |
| mem_rdata | input | 8 | Byte read from memory, valid the cycle after its address |
| io_valid | output | 1 | One-cycle strobe for a store to the reserved address |
| io_data | output | 8 | Byte carried by that store |
| halted | output | 1 | Machine has stopped |
| dbg_pc | output | 8 | Current program counter |
| dbg_ir | output | 16 | Current instruction register |

## Verification
The bench targets the byte order of the fetch. A core that swapped the two bytes would decode the address nibbles as the opcode and run a different program. It checks additions that overflow, since a sum kept wider than 8 bits or a wrong operand pick would leave a wrong byte in memory. Both outcomes of the compare-and-jump are run. A core that ignored the compare, or jumped on inequality, would execute the store that should have been skipped. It also drives undefined opcodes and keeps clocking after the stop instruction, so a stray register write, an extra write pulse, a missing output strobe or a PC that keeps moving shows up at the memory port.

// File: rtl/nibble_cpu_pkg.sv
package nibble_cpu_pkg;

  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 2 * BYTE_W;
  localparam int NIB_W   = 4;
  localparam int REGS    = 16;
  localparam int MADDR_W = 8;

  typedef enum logic [NIB_W-1:0] {
    OPC_LOAD  = 4'h1,
    OPC_STORE = 4'h3,
    OPC_ADD   = 4'h5,
    OPC_JUMP  = 4'hB,
    OPC_HALT  = 4'hC
  } opc_e;

  typedef enum logic [2:0] {
    ST_FETCH0,
    ST_FETCH1,
    ST_FETCH2,
    ST_DECODE,
    ST_EXEC,
    ST_WBACK,
    ST_STOP
  } phase_e;

endpackage

// File: rtl/nibble_cpu_regfile.sv
module nibble_cpu_regfile #(
  parameter int DATA_W = 8,
  parameter int NREG   = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_val,
  input  logic [IDX_W-1:0]  rd_idx_a,
  output logic [DATA_W-1:0] rd_val_a,
  input  logic [IDX_W-1:0]  rd_idx_b,
  output logic [DATA_W-1:0] rd_val_b,
  input  logic [IDX_W-1:0]  rd_idx_c,
  output logic [DATA_W-1:0] rd_val_c,
  output logic [DATA_W-1:0] rd_val_zero
);

  logic [DATA_W-1:0] bank [NREG];

  // One register slice per entry; each clears on reset and loads on a match.
  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        bank[gi] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(gi))) begin
        bank[gi] <= wr_val;
      end
    end
  end

  assign rd_val_a    = bank[rd_idx_a];
  assign rd_val_b    = bank[rd_idx_b];
  assign rd_val_c    = bank[rd_idx_c];
  assign rd_val_zero = bank[0];

endmodule

// File: rtl/nibble_cpu_decode.sv
module nibble_cpu_decode
  import nibble_cpu_pkg::*;
(
  input  logic [WORD_W-1:0]  instr,
  output logic               is_load,
  output logic               is_store,
  output logic               is_add,
  output logic               is_jump,
  output logic               is_halt,
  output logic [NIB_W-1:0]   fld_r,
  output logic [NIB_W-1:0]   fld_s,
  output logic [NIB_W-1:0]   fld_t,
  output logic [MADDR_W-1:0] fld_addr
);

  logic [NIB_W-1:0] opc;

  assign opc      = instr[WORD_W-1 -: NIB_W];
  assign fld_r    = instr[3*NIB_W-1 -: NIB_W];
  assign fld_s    = instr[2*NIB_W-1 -: NIB_W];
  assign fld_t    = instr[NIB_W-1:0];
  assign fld_addr = instr[MADDR_W-1:0];

  always_comb begin
    is_load  = 1'b0;
    is_store = 1'b0;
    is_add   = 1'b0;
    is_jump  = 1'b0;
    is_halt  = 1'b0;
    case (opc)
      OPC_LOAD:  is_load  = 1'b1;
      OPC_STORE: is_store = 1'b1;
      OPC_ADD:   is_add   = 1'b1;
      OPC_JUMP:  is_jump  = 1'b1;
      OPC_HALT:  is_halt  = 1'b1;
      default:   ;
    endcase
  end

endmodule

// File: rtl/nibble_cpu.sv
module nibble_cpu
  import nibble_cpu_pkg::*;
#(
  parameter logic [MADDR_W-1:0] IO_ADDR = 8'hFF
) (
  input  logic               clk,
  input  logic               rst,
  output logic [MADDR_W-1:0] mem_addr,
  output logic               mem_we,
  output logic [BYTE_W-1:0]  mem_wdata,
  input  logic [BYTE_W-1:0]  mem_rdata,
  output logic               io_valid,
  output logic [BYTE_W-1:0]  io_data,
  output logic               halted,
  output logic [MADDR_W-1:0] dbg_pc,
  output logic [WORD_W-1:0]  dbg_ir
);

  localparam int IDX_W = $clog2(REGS);

  phase_e             phase_q;
  logic [MADDR_W-1:0] pc_q;
  logic [WORD_W-1:0]  ir_q;

  logic               d_load, d_store, d_add, d_jump, d_halt;
  logic [NIB_W-1:0]   f_r, f_s, f_t;
  logic [MADDR_W-1:0] f_addr;

  logic               rf_we;
  logic [BYTE_W-1:0]  rf_wval;
  logic [BYTE_W-1:0]  v_s, v_t, v_r, v_zero;
  logic [BYTE_W-1:0]  sum;
  logic               jump_taken;

  nibble_cpu_decode u_dec (
    .instr    (ir_q),
    .is_load  (d_load),
    .is_store (d_store),
    .is_add   (d_add),
    .is_jump  (d_jump),
    .is_halt  (d_halt),
    .fld_r    (f_r),
    .fld_s    (f_s),
    .fld_t    (f_t),
    .fld_addr (f_addr)
  );

  nibble_cpu_regfile #(.DATA_W(BYTE_W), .NREG(REGS)) u_rf (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (rf_we),
    .wr_idx      (IDX_W'(f_r)),
    .wr_val      (rf_wval),
    .rd_idx_a    (IDX_W'(f_s)),
    .rd_val_a    (v_s),
    .rd_idx_b    (IDX_W'(f_t)),
    .rd_val_b    (v_t),
    .rd_idx_c    (IDX_W'(f_r)),
    .rd_val_c    (v_r),
    .rd_val_zero (v_zero)
  );

  assign sum        = v_s + v_t;
  assign jump_taken = d_jump && (v_r == v_zero);
  assign rf_we      = (phase_q == ST_WBACK) || ((phase_q == ST_EXEC) && d_add);
  assign rf_wval    = (phase_q == ST_WBACK) ? mem_rdata : sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= ST_FETCH0;
      pc_q      <= '0;
      ir_q      <= '0;
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      io_valid  <= 1'b0;
      io_data   <= '0;
      halted    <= 1'b0;
    end else begin
      mem_we   <= 1'b0;
      io_valid <= 1'b0;
      case (phase_q)
        ST_FETCH0: begin
          mem_addr <= pc_q + MADDR_W'(1);
          phase_q  <= ST_FETCH1;
        end
        ST_FETCH1: begin
          ir_q[WORD_W-1 -: BYTE_W] <= mem_rdata;
          phase_q <= ST_FETCH2;
        end
        ST_FETCH2: begin
          ir_q[BYTE_W-1:0] <= mem_rdata;
          pc_q    <= pc_q + MADDR_W'(2);
          phase_q <= ST_DECODE;
        end
        ST_DECODE: begin
          if (d_load || d_store) begin
            mem_addr <= f_addr;
          end
          if (d_store) begin
            mem_we    <= 1'b1;
            mem_wdata <= v_r;
            if (f_addr == IO_ADDR) begin
              io_valid <= 1'b1;
              io_data  <= v_r;
            end
          end
          phase_q <= ST_EXEC;
        end
        ST_EXEC: begin
          if (d_halt) begin
            halted  <= 1'b1;
            phase_q <= ST_STOP;
          end else if (d_load) begin
            phase_q <= ST_WBACK;
          end else begin
            if (jump_taken) begin
              pc_q     <= f_addr;
              mem_addr <= f_addr;
            end else begin
              mem_addr <= pc_q;
            end
            phase_q <= ST_FETCH0;
          end
        end
        ST_WBACK: begin
          mem_addr <= pc_q;
          phase_q  <= ST_FETCH0;
        end
        default: phase_q <= ST_STOP;
      endcase
    end
  end

  assign dbg_pc = pc_q;
  assign dbg_ir = ir_q;

endmodule

// File: rtl/nibble_cpu_chk.sv
module nibble_cpu_chk #(
  parameter logic [7:0] IO_ADDR = 8'hFF
) (
  input logic       clk,
  input logic       rst,
  input logic       halted,
  input logic       mem_we,
  input logic       io_valid,
  input logic [7:0] mem_addr,
  input logic [7:0] dbg_pc
);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dbg_pc == 8'h00 && !halted && !mem_we));

  // R4
  store_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R8
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we);

  // R8
  halt_pc_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(dbg_pc));

  // R9
  io_addr_chk: assert property (@(posedge clk) disable iff (rst)
    io_valid |-> (mem_we && mem_addr == IO_ADDR));

endmodule

bind nibble_cpu nibble_cpu_chk #(.IO_ADDR(IO_ADDR)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .halted   (halted),
  .mem_we   (mem_we),
  .io_valid (io_valid),
  .mem_addr (mem_addr),
  .dbg_pc   (dbg_pc)
);

// File: tb/nibble_cpu_tb.sv
module nibble_cpu_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  mem_addr;
  logic        mem_we;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic        io_valid;
  logic [7:0]  io_data;
  logic        halted;
  logic [7:0]  dbg_pc;
  logic [15:0] dbg_ir;

  logic        ld_en = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [7:0]  ld_data = '0;
  logic [7:0]  mem [256];

  int nchk  = 0;
  int nfail = 0;
  int we_cnt;
  int io_cnt;
  logic [7:0] io_last;

  always #5 clk = ~clk;

  nibble_cpu u_dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .io_valid(io_valid),
    .io_data(io_data), .halted(halted), .dbg_pc(dbg_pc), .dbg_ir(dbg_ir)
  );

  // Synchronous single-port memory model with a loader path.
  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  always @(negedge clk) begin
    if (rst) begin
      we_cnt  <= 0;
      io_cnt  <= 0;
      io_last <= '0;
    end else begin
      if (mem_we) we_cnt <= we_cnt + 1;
      if (io_valid) begin
        io_cnt  <= io_cnt + 1;
        io_last <= io_data;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic put16(input logic [7:0] a, input logic [15:0] w);
    poke(a, w[15:8]);
    poke(a + 8'd1, w[7:0]);
  endtask

  task automatic prepare();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 256; i++) poke(8'(i), 8'hEE);
  endtask

  task automatic launch();
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_to_stop(input string tag);
    int n = 0;
    while (!halted && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check({tag, " stop reached"}, 32'(halted), 32'd1);
  endtask

  task automatic t_reset_fetch();
    prepare();
    put16(8'h00, 16'h156C);
    put16(8'h02, 16'hC000);
    @(negedge clk);
    // R1: state held in reset
    check("R1 pc in reset", 32'(dbg_pc), 32'h00);
    check("R1 ir in reset", 32'(dbg_ir), 32'h0000);
    check("R1 halted in reset", 32'(halted), 32'd0);
    check("R1 we in reset", 32'(mem_we), 32'd0);
    launch();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2: high byte first, PC advanced by two
    check("R2 ir after fetch", 32'(dbg_ir), 32'h156C);
    check("R2 pc after fetch", 32'(dbg_pc), 32'h02);
    run_to_stop("R2");
  endtask

  task automatic t_regs_zero();
    prepare();
    put16(8'h00, 16'h3780);
    put16(8'h02, 16'hC000);
    launch();
    run_to_stop("R1");
    check("R1 reg7 reads zero", 32'(mem[8'h80]), 32'h00);
  endtask

  task automatic t_main_program();
    prepare();
    put16(8'h00, 16'h156C);
    put16(8'h02, 16'h166D);
    put16(8'h04, 16'h5056);
    put16(8'h06, 16'h306E);
    put16(8'h08, 16'hC000);
    put16(8'h0A, 16'h356F);
    poke(8'h6C, 8'h2B);
    poke(8'h6D, 8'hFF);
    launch();
    run_to_stop("R8");
    // R3 R5: 0x2B + 0xFF wraps to 0x2A
    check("R5 wrapped sum stored", 32'(mem[8'h6E]), 32'h2A);
    check("R3 loaded operand kept", 32'(mem[8'h6C]), 32'h2B);
    check("R4 single write pulse", 32'(we_cnt), 32'd1);
    check("R9 no strobe off-address", 32'(io_cnt), 32'd0);
    check("R8 pc at stop", 32'(dbg_pc), 32'h0A);
    check("R2 ir at stop", 32'(dbg_ir), 32'hC000);
    repeat (20) @(negedge clk);
    check("R8 pc frozen", 32'(dbg_pc), 32'h0A);
    check("R8 still stopped", 32'(halted), 32'd1);
    check("R8 no write after stop", 32'(we_cnt), 32'd1);
    check("R8 next store not run", 32'(mem[8'h6F]), 32'hEE);
  endtask

  task automatic t_add_cases();
    prepare();
    put16(8'h00, 16'h1190);
    put16(8'h02, 16'h1291);
    put16(8'h04, 16'h5312);
    put16(8'h06, 16'h5111);
    put16(8'h08, 16'h33B0);
    put16(8'h0A, 16'h31B1);
    put16(8'h0C, 16'hC000);
    poke(8'h90, 8'h80);
    poke(8'h91, 8'h7F);
    launch();
    run_to_stop("R5");
    check("R5 0x80+0x7F", 32'(mem[8'hB0]), 32'hFF);
    check("R5 self add wraps", 32'(mem[8'hB1]), 32'h00);
  endtask

  task automatic t_jump(input logic [7:0] cmp_val, input logic taken);
    prepare();
    put16(8'h00, 16'h1290);
    put16(8'h02, 16'hB20A);
    put16(8'h04, 16'h1391);
    put16(8'h06, 16'h33A0);
    put16(8'h08, 16'hC000);
    put16(8'h0A, 16'h1492);
    put16(8'h0C, 16'h34A1);
    put16(8'h0E, 16'hC000);
    poke(8'h90, cmp_val);
    poke(8'h91, 8'h33);
    poke(8'h92, 8'h44);
    launch();
    run_to_stop("R6/R7");
    if (taken) begin
      // R6
      check("R6 skipped store", 32'(mem[8'hA0]), 32'hEE);
      check("R6 target store", 32'(mem[8'hA1]), 32'h44);
      check("R6 pc at stop", 32'(dbg_pc), 32'h10);
    end else begin
      // R7
      check("R7 fall-through store", 32'(mem[8'hA0]), 32'h33);
      check("R7 target untouched", 32'(mem[8'hA1]), 32'hEE);
      check("R7 pc at stop", 32'(dbg_pc), 32'h0A);
    end
  endtask

  task automatic t_undefined();
    prepare();
    put16(8'h00, 16'h1190);
    put16(8'h02, 16'h7123);
    put16(8'h04, 16'h2190);
    put16(8'h06, 16'hF1FF);
    put16(8'h08, 16'h0000);
    put16(8'h0A, 16'h3191);
    put16(8'h0C, 16'hC000);
    poke(8'h90, 8'h11);
    launch();
    run_to_stop("R10");
    check("R10 register unchanged", 32'(mem[8'h91]), 32'h11);
    check("R10 only one write", 32'(we_cnt), 32'd1);
    check("R10 no write at FF", 32'(mem[8'hFF]), 32'hEE);
  endtask

  task automatic t_io();
    prepare();
    put16(8'h00, 16'h1590);
    put16(8'h02, 16'h35FF);
    put16(8'h04, 16'h3591);
    put16(8'h06, 16'hC000);
    poke(8'h90, 8'h5A);
    launch();
    run_to_stop("R9");
    check("R9 one strobe", 32'(io_cnt), 32'd1);
    check("R9 strobe data", 32'(io_last), 32'h5A);
    check("R9 memory written", 32'(mem[8'hFF]), 32'h5A);
    check("R4 plain store", 32'(mem[8'h91]), 32'h5A);
    check("R4 two write pulses", 32'(we_cnt), 32'd2);
  endtask

  initial begin
    t_reset_fetch();
    t_regs_zero();
    t_main_program();
    t_add_cases();
    t_jump(8'h00, 1'b1);
    t_jump(8'h01, 1'b0);
    t_undefined();
    t_io();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual expired expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule